// File: doc/BRIEF.md
# Legacy Low-Memory Shadow and SMRAM Steering Decoder

This block sits in the memory path of a host bridge and decides, for every CPU access to the region below 1 MiB, whether it is served by DRAM or forwarded to the PCI bus. Thirteen shadow regions in the upper part of that space each have a 2-bit attribute. One bit steers reads and the other steers writes. This lets firmware copy option ROMs and the boot ROM into DRAM and then run them from there. The attributes are packed two per byte into seven configuration bytes.

A separate 128 KiB graphics/SMRAM window at 0xA0000 to 0xBFFFF is governed by one control byte. Ordinary accesses see DRAM in that window only while an open bit is set. Accesses made in system-management mode see DRAM whenever a global enable bit is set. Every other address below 1 MiB goes to DRAM.

Configuration bytes are written and read through a simple byte port. Each access is presented with a valid strobe. The decode result appears on registered outputs one cycle later.

Top module: `lowmem_steer`

## Requirements
- R1: While reset is asserted and after it is released, `acc_en_o` and `tgt_dram_o` are 0. The seven attribute bytes at offsets 0x59 to 0x5F read back 0x00, and the SMRAM control byte at offset 0x72 reads back 0x02.
- R2: A write to offsets 0x59 to 0x5F or to 0x72 stores the full byte, and that byte is read back combinationally on `cfg_rdata_o`. A write to any other offset changes no stored state, and a read of any other offset returns 0x00.
- R3: Expansion region k (k = 1..12) covers 16 KiB starting at 0xC0000 + (k-1)*0x4000. Its attribute comes from byte 0x59 + ceil(k/2). Odd k uses bits [1:0] of that byte and even k uses bits [5:4].
- R4: Within a region's 2-bit attribute, bit 0 set sends reads to DRAM and bit 1 set sends writes to DRAM. A cleared bit sends that access type to PCI (`tgt_dram_o` = 0).
- R5: The boot ROM region 0xF0000 to 0xFFFFF takes its attribute from bits [5:4] of byte 0x59.
- R6: For a non-SMM access in 0xA0000 to 0xBFFFF, the target is DRAM when bit 6 (open) of the SMRAM byte is set and PCI when it is clear.
- R7: For an SMM access in 0xA0000 to 0xBFFFF, the target is DRAM when bit 3 (global enable) of the SMRAM byte is set. When bit 3 is clear, the rule of R6 applies.
- R8: Addresses below 0xA0000 go to DRAM regardless of any configuration.
- R9: `acc_en_o` is 1 exactly in the cycle after `acc_valid_i` was sampled high, and `tgt_dram_o` then carries the decode. Otherwise both are 0. The decode uses the configuration as it stood in the cycle the access was sampled: a configuration write in the same cycle affects only later accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration byte write strobe |
| cfg_addr_i | input | 8 | Configuration byte offset for write and read |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration read data for `cfg_addr_i` |
| acc_valid_i | input | 1 | An access is presented this cycle |
| acc_addr_i | input | 20 | Access byte address |
| acc_write_i | input | 1 | 1 for a write access, 0 for a read |
| acc_smm_i | input | 1 | Access is made in system-management mode |
| acc_en_o | output | 1 | Decode result valid (one cycle after the access) |
| tgt_dram_o | output | 1 | 1 routes the access to DRAM, 0 to PCI |

## Verification
A corrupted attribute nibble or a mis-wired byte or nibble index shows as a wrong `tgt_dram_o` on the very next cycle of any access to the affected region. The same access also reads or writes through the wrong neighbouring region. For that reason the sweep programs one region at a time and probes all thirteen. A wrong open or enable bit in the SMRAM byte appears one cycle after a window access, and only for the matching SMM/non-SMM case. All four bit combinations are therefore crossed with both modes. Lost or misdirected configuration writes are visible immediately on the combinational readback.

// File: rtl/lowmem_pkg.sv
package lowmem_pkg;
  localparam int CFG_W = 8;
  typedef logic [CFG_W-1:0] cfg_byte_t;

  localparam int        ATTR_OFS  = 32'h59;
  localparam int        SMRAM_OFS = 32'h72;
  localparam cfg_byte_t SMRAM_RST = 8'h02;

  localparam int OPEN_BIT = 6;
  localparam int GEN_BIT  = 3;
  localparam int RD_BIT   = 0;
  localparam int WR_BIT   = 1;
endpackage

// File: rtl/lowmem_cfg_regs.sv
module lowmem_cfg_regs
  import lowmem_pkg::*;
#(
  parameter int NUM_BYTES = 7
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            cfg_we_i,
  input  cfg_byte_t                       cfg_addr_i,
  input  cfg_byte_t                       cfg_wdata_i,
  output cfg_byte_t                       cfg_rdata_o,
  output logic [NUM_BYTES-1:0][CFG_W-1:0] attr_o,
  output cfg_byte_t                       smram_o
);
  logic [NUM_BYTES-1:0][CFG_W-1:0] attr_q;
  cfg_byte_t                       smram_q;
  logic                            in_range;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_attr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       attr_q[b] <= '0;
      else if (cfg_we_i && 32'(cfg_addr_i) == ATTR_OFS + b) attr_q[b] <= cfg_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                          smram_q <= SMRAM_RST;
    else if (cfg_we_i && 32'(cfg_addr_i) == SMRAM_OFS)    smram_q <= cfg_wdata_i;
  end

  always_comb begin
    cfg_rdata_o = '0;
    for (int b = 0; b < NUM_BYTES; b++)
      if (32'(cfg_addr_i) == ATTR_OFS + b) cfg_rdata_o = attr_q[b];
    if (32'(cfg_addr_i) == SMRAM_OFS) cfg_rdata_o = smram_q;
  end

  assign attr_o  = attr_q;
  assign smram_o = smram_q;

  assign in_range = (32'(cfg_addr_i) == SMRAM_OFS) ||
                    (32'(cfg_addr_i) >= ATTR_OFS && 32'(cfg_addr_i) < ATTR_OFS + NUM_BYTES);

  a_r2_smram_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && 32'(cfg_addr_i) == SMRAM_OFS) |=> (smram_o == $past(cfg_wdata_i)));

  a_r2_foreign_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !in_range) |=> ($stable(smram_o) && $stable(attr_o)));
endmodule

// File: rtl/lowmem_shadow_decode.sv
module lowmem_shadow_decode
  import lowmem_pkg::*;
#(
  parameter int          ADDR_W     = 20,
  parameter int          NUM_EXP    = 12,
  parameter int          NUM_BYTES  = 7,
  parameter int unsigned BIOS_BASE  = 32'hF0000,
  parameter int          BIOS_SHIFT = 16,
  parameter int unsigned EXP_BASE   = 32'hC0000,
  parameter int          EXP_SHIFT  = 14
) (
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic                            write_i,
  input  logic [NUM_BYTES-1:0][CFG_W-1:0] attr_i,
  output logic                            hit_o,
  output logic                            dram_o
);
  localparam int NUM_REG = NUM_EXP + 1;

  logic [NUM_REG-1:0] hit, perm;
  logic               unused_attr_bits;

  for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
    localparam int          SH     = (r == 0) ? BIOS_SHIFT : EXP_SHIFT;
    localparam int unsigned BASE   = (r == 0) ? BIOS_BASE
                                              : EXP_BASE + ((r - 1) << EXP_SHIFT);
    localparam int          BYTE_I = (r + 1) / 2;
    logic [1:0] nib;
    // even regions (including the boot ROM one) sit in the upper nibble
    if (r % 2 == 0) begin : g_hi
      assign nib = attr_i[BYTE_I][5:4];
    end else begin : g_lo
      assign nib = attr_i[BYTE_I][1:0];
    end
    assign hit[r]  = (32'(addr_i) >> SH) == (BASE >> SH);
    assign perm[r] = write_i ? nib[WR_BIT] : nib[RD_BIT];
  end

  assign hit_o            = |hit;
  assign dram_o           = |(hit & perm);
  assign unused_attr_bits = ^attr_i;
endmodule

// File: rtl/lowmem_smram_window.sv
module lowmem_smram_window #(
  parameter int          ADDR_W    = 20,
  parameter int unsigned WIN_BASE  = 32'hA0000,
  parameter int          WIN_SHIFT = 17
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              smm_i,
  input  logic              open_i,
  input  logic              gen_i,
  output logic              hit_o,
  output logic              dram_o
);
  assign hit_o  = (32'(addr_i) >> WIN_SHIFT) == (WIN_BASE >> WIN_SHIFT);
  assign dram_o = open_i || (smm_i && gen_i);
endmodule

// File: rtl/lowmem_steer.sv
module lowmem_steer
  import lowmem_pkg::*;
#(
  parameter int          ADDR_W     = 20,
  parameter int          NUM_EXP    = 12,
  parameter int unsigned BIOS_BASE  = 32'hF0000,
  parameter int          BIOS_SHIFT = 16,
  parameter int unsigned EXP_BASE   = 32'hC0000,
  parameter int          EXP_SHIFT  = 14,
  parameter int unsigned WIN_BASE   = 32'hA0000,
  parameter int          WIN_SHIFT  = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [7:0]        cfg_addr_i,
  input  logic [7:0]        cfg_wdata_i,
  output logic [7:0]        cfg_rdata_o,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_write_i,
  input  logic              acc_smm_i,
  output logic              acc_en_o,
  output logic              tgt_dram_o
);
  localparam int          NUM_REG   = NUM_EXP + 1;
  localparam int          NUM_BYTES = (NUM_REG + 2) / 2;
  localparam int unsigned WIN_END   = WIN_BASE + (32'd1 << WIN_SHIFT);

  logic [NUM_BYTES-1:0][CFG_W-1:0] attr;
  cfg_byte_t                       smram;
  logic                            sh_hit, sh_dram, win_hit, win_dram;
  logic                            dram_d, en_q, dram_q;
  logic                            unused_smram_bits;

  lowmem_cfg_regs #(.NUM_BYTES(NUM_BYTES)) u_cfg (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i, .cfg_rdata_o,
    .attr_o (attr),
    .smram_o(smram)
  );

  lowmem_shadow_decode #(
    .ADDR_W(ADDR_W), .NUM_EXP(NUM_EXP), .NUM_BYTES(NUM_BYTES),
    .BIOS_BASE(BIOS_BASE), .BIOS_SHIFT(BIOS_SHIFT),
    .EXP_BASE(EXP_BASE), .EXP_SHIFT(EXP_SHIFT)
  ) u_shadow (
    .addr_i (acc_addr_i),
    .write_i(acc_write_i),
    .attr_i (attr),
    .hit_o  (sh_hit),
    .dram_o (sh_dram)
  );

  lowmem_smram_window #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_SHIFT(WIN_SHIFT)
  ) u_win (
    .addr_i(acc_addr_i),
    .smm_i (acc_smm_i),
    .open_i(smram[OPEN_BIT]),
    .gen_i (smram[GEN_BIT]),
    .hit_o (win_hit),
    .dram_o(win_dram)
  );

  always_comb begin
    if (win_hit)     dram_d = win_dram;
    else if (sh_hit) dram_d = sh_dram;
    else             dram_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      dram_q <= 1'b0;
    end else begin
      en_q   <= acc_valid_i;
      dram_q <= acc_valid_i && dram_d;
    end
  end

  assign acc_en_o          = en_q;
  assign tgt_dram_o        = dram_q;
  assign unused_smram_bits = ^smram;

  a_r6_closed_to_pci: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !acc_smm_i && !smram[OPEN_BIT] &&
     32'(acc_addr_i) >= WIN_BASE && 32'(acc_addr_i) < WIN_END) |=> !tgt_dram_o);

  a_r7_smm_to_dram: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_smm_i && smram[GEN_BIT] &&
     32'(acc_addr_i) >= WIN_BASE && 32'(acc_addr_i) < WIN_END) |=> tgt_dram_o);

  a_r8_low_to_dram: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && 32'(acc_addr_i) < WIN_BASE) |=> (acc_en_o && tgt_dram_o));

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> (!acc_en_o && !tgt_dram_o));

  a_r9_result_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i |=> acc_en_o);
endmodule

// File: tb/lowmem_steer_test.sv
module lowmem_steer_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        acc_valid = 1'b0;
  logic [19:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic        acc_smm = 1'b0;
  logic        acc_en;
  logic        tgt_dram;

  int checks = 0;
  int errors = 0;

  logic [7:0] pam_m [7];
  logic [7:0] sm_m;

  always #(CLK_P/2) clk = ~clk;

  lowmem_steer uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata),
    .acc_valid_i(acc_valid), .acc_addr_i(acc_addr),
    .acc_write_i(acc_write), .acc_smm_i(acc_smm),
    .acc_en_o(acc_en), .tgt_dram_o(tgt_dram)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_dram(input int unsigned a, input bit w, input bit s);
    int r, bi;
    logic [1:0] nib;
    if (a >= 'hA0000 && a < 'hC0000) return sm_m[6] || (s && sm_m[3]);
    if (a < 'hA0000) return 1'b1;
    if (a >= 'hF0000) r = 0;
    else r = 1 + int'((a - 'hC0000) / 16384);
    bi  = (r + 1) / 2;
    nib = (r % 2 == 0) ? pam_m[bi][5:4] : pam_m[bi][1:0];
    return w ? nib[1] : nib[0];
  endfunction

  function automatic int unsigned rbase(input int r);
    return (r == 0) ? 32'hF0000 : 32'hC0000 + (r - 1) * 16384;
  endfunction

  function automatic int unsigned rsize(input int r);
    return (r == 0) ? 65536 : 16384;
  endfunction

  task automatic cfg_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a >= 8'h59 && a <= 8'h5F) pam_m[a - 8'h59] = d;
    if (a == 8'h72) sm_m = d;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] e, input string req);
    cfg_addr = a;
    #1;
    chk(cfg_rdata === e, req, int'(cfg_rdata), int'(e));
  endtask

  task automatic probe(input int unsigned a, input bit w, input bit s, input string req);
    bit e;
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a[19:0]; acc_write = w; acc_smm = s;
    e = exp_dram(a, w, s);
    @(negedge clk);
    chk(acc_en === 1'b1 && tgt_dram === e, req, int'({acc_en, tgt_dram}), int'({1'b1, e}));
    acc_valid = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 7; i++) pam_m[i] = 8'h00;
    sm_m = 8'h02;

    // R1: during and after reset
    #(CLK_P * 2 + 1);
    chk(acc_en === 1'b0 && tgt_dram === 1'b0, "R1 in reset", int'({acc_en, tgt_dram}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(acc_en === 1'b0 && tgt_dram === 1'b0, "R1 after reset", int'({acc_en, tgt_dram}), 0);
    for (int i = 0; i < 7; i++) rd_chk(8'(8'h59 + i), 8'h00, "R1 attr reset");
    rd_chk(8'h72, 8'h02, "R1 smram reset");

    // R2: store and read back
    for (int i = 0; i < 7; i++) cfg_wr(8'(8'h59 + i), 8'(8'hA5 ^ (i * 8'h13)));
    cfg_wr(8'h72, 8'h5C);
    for (int i = 0; i < 7; i++) rd_chk(8'(8'h59 + i), 8'(8'hA5 ^ (i * 8'h13)), "R2 attr readback");
    rd_chk(8'h72, 8'h5C, "R2 smram readback");
    for (int i = 0; i < 7; i++) cfg_wr(8'(8'h59 + i), 8'h00);
    cfg_wr(8'h72, 8'h02);

    // R2: foreign offsets ignored
    cfg_wr(8'h58, 8'hFF);
    cfg_wr(8'h60, 8'hFF);
    cfg_wr(8'h71, 8'hFF);
    cfg_wr(8'h73, 8'hFF);
    rd_chk(8'h58, 8'h00, "R2 foreign read");
    rd_chk(8'h60, 8'h00, "R2 foreign read");
    rd_chk(8'h59, 8'h00, "R2 neighbour unchanged");
    rd_chk(8'h5F, 8'h00, "R2 neighbour unchanged");
    rd_chk(8'h72, 8'h02, "R2 smram unchanged");
    probe(32'hC0000, 1'b0, 1'b0, "R2 decode unchanged");
    probe(32'hFFFFF, 1'b1, 1'b0, "R2 decode unchanged");
    probe(32'hA0000, 1'b0, 1'b0, "R2 decode unchanged");

    // R3 R4 R5: one region programmed at a time, all regions probed
    for (int r = 0; r < 13; r++) begin
      for (int v = 0; v < 4; v++) begin
        int bi;
        logic [7:0] d;
        bi = (r + 1) / 2;
        d  = (r % 2 == 0) ? 8'(v << 4) : 8'(v);
        cfg_wr(8'(8'h59 + bi), d);
        for (int q = 0; q < 13; q++) begin
          probe(rbase(q), 1'b0, 1'b0, (q == 0) ? "R5 boot rom read" : "R3/R4 read");
          probe(rbase(q), 1'b1, 1'b0, (q == 0) ? "R5 boot rom write" : "R3/R4 write");
        end
        probe(rbase(r) + rsize(r) - 1, 1'b0, 1'b1, "R3 region end read");
        probe(rbase(r) + rsize(r) - 1, 1'b1, 1'b1, "R4 region end write");
        cfg_wr(8'(8'h59 + bi), 8'h00);
      end
    end

    // R6 R7: window, all open/enable combos crossed with mode and direction
    for (int v = 0; v < 4; v++) begin
      logic [7:0] sv;
      sv = 8'h02 | (v[1] ? 8'h40 : 8'h00) | (v[0] ? 8'h08 : 8'h00) | ((v == 2) ? 8'h85 : 8'h00);
      cfg_wr(8'h72, sv);
      for (int s = 0; s < 2; s++) begin
        for (int w = 0; w < 2; w++) begin
          probe(32'hA0000, w[0], s[0], s ? "R7 window start" : "R6 window start");
          probe(32'hB1234, w[0], s[0], s ? "R7 window mid" : "R6 window mid");
          probe(32'hBFFFF, w[0], s[0], s ? "R7 window end" : "R6 window end");
          probe(32'h9FFFF, w[0], s[0], "R8 below window");
          probe(32'hC0000, w[0], s[0], "R3 above window");
        end
      end
    end

    // R8: low memory with every attribute set and cleared
    for (int i = 0; i < 7; i++) cfg_wr(8'(8'h59 + i), 8'hFF);
    cfg_wr(8'h72, 8'h00);
    probe(32'h00000, 1'b0, 1'b0, "R8 low read");
    probe(32'h12345, 1'b1, 1'b1, "R8 low write");
    for (int i = 0; i < 7; i++) cfg_wr(8'(8'h59 + i), 8'h00);
    probe(32'h7FFFF, 1'b0, 1'b0, "R8 low read cleared");
    probe(32'h9FFFF, 1'b1, 1'b0, "R8 low write cleared");

    // R9: same-cycle config write uses old state, next access sees new
    cfg_wr(8'h72, 8'h02);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 8'h72; cfg_wdata = 8'h42;
    acc_valid = 1'b1; acc_addr = 20'hA0000; acc_write = 1'b0; acc_smm = 1'b0;
    @(negedge clk);
    chk(acc_en === 1'b1 && tgt_dram === 1'b0, "R9 old config used",
        int'({acc_en, tgt_dram}), 2);
    cfg_we = 1'b0;
    sm_m = 8'h42;
    @(negedge clk);
    chk(acc_en === 1'b1 && tgt_dram === 1'b1, "R9 new config next",
        int'({acc_en, tgt_dram}), 3);
    acc_valid = 1'b0;
    acc_addr = 20'h00000;
    @(negedge clk);
    chk(acc_en === 1'b0 && tgt_dram === 1'b0, "R9 idle after access",
        int'({acc_en, tgt_dram}), 0);
    @(negedge clk);
    chk(acc_en === 1'b0 && tgt_dram === 1'b0, "R9 idle stays quiet",
        int'({acc_en, tgt_dram}), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule